// File: doc/BRIEF.md
# Eight-bit ALU with carry control

This block is the arithmetic-logic unit of a small microcoded datapath. A five-bit control word carries a four-bit function code and a store-flags enable. The two operands pass through a combinational network that gives an add with one of four carry-in sources or with the carry held, NOR, pass and clear, four right shifts, and a pass of B that sets, holds or inverts the carry. The result, carry-out, zero and negative outputs are valid in the same cycle as the inputs.

A three-bit flag register holds carry, zero and negative. It loads the outputs of the current operation on the rising clock edge only when the store-flags bit is set. The stored carry feeds back into the add, rotate-through-carry and carry-manipulation functions. Operand sourcing, the register file and sequencing are outside this block. When the sequencer routes the same register to both operands, the add functions act as a left shift by one.

Top module: `carry_alu`

## Requirements
- R1: Bit 0 of the control word is the store-flags enable and bits 4:1 are the function code; only these field positions select the behaviour.
- R2: Codes 0100, 0101, 0110 and 0111 give A+B with carry-in 0, 1, stored carry C and inverted C respectively; the result is the low eight bits and carry-out is bit 8 of the sum.
- R3: Code 0000 gives A+B with carry-in 0, and its carry-out equals the stored carry, so a flag store leaves C unchanged.
- R4: With A equal to B, the add codes give A shifted left by one with the selected carry-in as the new bit 0, and carry-out equal to the old bit 7.
- R5: Code 0001 gives A, 0010 gives NOR of A and B, and 0011 gives zero; each has carry-out 0.
- R6: Code 1000 shifts A right with a 0 entering bit 7, and 1001 rotates A right with bit 0 entering bit 7; carry-out is the old bit 0.
- R7: Code 1010 shifts A right with the stored carry entering bit 7, and 1011 shifts A right keeping bit 7; carry-out is the old bit 0.
- R8: Codes 1100 to 1111 give B, with carry-out 0, 1, C and the inverse of C respectively.
- R9: The zero output is 1 exactly when the result is all zeros, and the negative output equals result bit 7.
- R10: The flag register is all zeros during and after reset, and on a clock edge with the store bit at 1 it loads carry-out, zero and negative.
- R11: On a clock edge with the store bit at 0 the flag register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 5 | Control word: bits 4:1 function code, bit 0 store-flags enable |
| opa_i | input | 8 | Operand A |
| opb_i | input | 8 | Operand B |
| res_o | output | 8 | Result |
| cout_o | output | 1 | Carry-out of the current operation |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result bit 7 |
| flag_c_o | output | 1 | Stored carry flag |
| flag_z_o | output | 1 | Stored zero flag |
| flag_n_o | output | 1 | Stored negative flag |

## Verification
The assertions assume that the control word and operands are stable and known around each rising edge, because the outputs are combinational and the flag register samples them. The bench changes inputs only on falling edges and drives defined values from reset onwards. The carry-dependent assertions assume the stored carry is set by an earlier legal operation, so the stimulus builds known flag states with set, hold and invert codes before the carry-consuming add and rotate codes, and mixes directed equal-operand cases with long random runs.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;

   // Function codes; the numeric values are decoded by the datapath.
   typedef enum logic [3:0] {
      FN_ADD_HOLD  = 4'b0000,
      FN_PASS_A    = 4'b0001,
      FN_NOR       = 4'b0010,
      FN_CLEAR     = 4'b0011,
      FN_ADD       = 4'b0100,
      FN_ADD_ONE   = 4'b0101,
      FN_ADD_C     = 4'b0110,
      FN_ADD_NC    = 4'b0111,
      FN_SHR_LOG   = 4'b1000,
      FN_SHR_ROT   = 4'b1001,
      FN_SHR_THRU  = 4'b1010,
      FN_SHR_ARITH = 4'b1011,
      FN_PASS_B    = 4'b1100,
      FN_B_SETC    = 4'b1101,
      FN_B_HOLDC   = 4'b1110,
      FN_B_INVC    = 4'b1111
   } alu_fn_e;

   // Function groups taken from the upper two code bits.
   localparam logic [1:0] GRP_LOGIC = 2'b00;
   localparam logic [1:0] GRP_ADD   = 2'b01;
   localparam logic [1:0] GRP_SHIFT = 2'b10;
   localparam logic [1:0] GRP_PASSB = 2'b11;

   // Carry-in / sub-mode selector from the lower two code bits.
   localparam logic [1:0] SUB_0 = 2'b00;
   localparam logic [1:0] SUB_1 = 2'b01;
   localparam logic [1:0] SUB_2 = 2'b10;
   localparam logic [1:0] SUB_3 = 2'b11;

   typedef struct packed {
      logic c;
      logic z;
      logic n;
   } alu_flags_t;

   localparam alu_flags_t FLAGS_RESET = '{c: 1'b0, z: 1'b0, n: 1'b0};

   function automatic logic [1:0] fn_group(input logic [3:0] code);
      return code[3:2];
   endfunction

   function automatic logic [1:0] fn_sub(input logic [3:0] code);
      return code[1:0];
   endfunction

endpackage

// File: rtl/carry_alu_adder.sv
module carry_alu_adder #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);

   localparam int SUM_W = WIDTH + 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("carry_alu_adder: WIDTH must be at least 2");
   end

   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] chain;
      assign chain[0] = cin_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic p;
         assign p           = a_i[i] ^ b_i[i];
         assign sum_o[i]    = p ^ chain[i];
         assign chain[i+1]  = (a_i[i] & b_i[i]) | (p & chain[i]);
      end
      assign cout_o = chain[WIDTH];
   end else begin : g_infer
      logic [SUM_W-1:0] wide;
      assign wide   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
      assign sum_o  = wide[WIDTH-1:0];
      assign cout_o = wide[WIDTH];
   end

endmodule

// File: rtl/carry_alu_shifter.sv
module carry_alu_shifter #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic             cflag_i,
   input  logic [1:0]       mode_i,
   output logic [WIDTH-1:0] y_o,
   output logic             out_bit_o
);
   import carry_alu_pkg::*;

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("carry_alu_shifter: WIDTH must be at least 2");
   end

   // Lower bits always take the next bit up.
   for (genvar i = 0; i < MSB; i++) begin : g_move
      assign y_o[i] = a_i[i+1];
   end

   // Only the bit entering the top differs between the four flavours.
   logic fill;
   always_comb begin
      unique case (mode_i)
         SUB_0:   fill = 1'b0;       // logical
         SUB_1:   fill = a_i[0];     // rotate
         SUB_2:   fill = cflag_i;    // through carry
         default: fill = a_i[MSB];   // sign kept
      endcase
   end

   assign y_o[MSB]  = fill;
   assign out_bit_o = a_i[0];

endmodule

// File: rtl/carry_alu_flags.sv
module carry_alu_flags
   import carry_alu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  alu_flags_t next_i,
   output alu_flags_t flags_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_o <= FLAGS_RESET;
      end else if (load_i) begin
         flags_o <= next_i;
      end
   end

   // R10: a store loads exactly what was presented
   p_flags_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> flags_o == $past(next_i));

   // R11: without a store the flags keep their value
   p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(flags_o));

endmodule

// File: rtl/carry_alu.sv
module carry_alu
   import carry_alu_pkg::*;
#(
   parameter int WIDTH        = 8,
   parameter bit RIPPLE_ADDER = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [4:0]       ctrl_i,
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o,
   output logic             zero_o,
   output logic             neg_o,
   output logic             flag_c_o,
   output logic             flag_z_o,
   output logic             flag_n_o
);

   localparam int STORE_BIT = 0;
   localparam int FN_LSB    = 1;
   localparam int FN_MSB    = FN_LSB + 3;
   localparam int MSB       = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("carry_alu: WIDTH must be at least 2");
   end

   logic [3:0] fn;
   logic       store;
   logic [1:0] grp;
   logic [1:0] sub;
   assign fn    = ctrl_i[FN_MSB:FN_LSB];
   assign store = ctrl_i[STORE_BIT];
   assign grp   = fn_group(fn);
   assign sub   = fn_sub(fn);

   alu_flags_t flags_q;
   alu_flags_t flags_d;

   // Carry-in: the hold-carry add shares the sub-code 00 with the plain add.
   logic cin;
   always_comb begin
      unique case (sub)
         SUB_0:   cin = 1'b0;
         SUB_1:   cin = 1'b1;
         SUB_2:   cin = flags_q.c;
         default: cin = ~flags_q.c;
      endcase
   end

   logic [WIDTH-1:0] sum;
   logic             sum_c;
   carry_alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE_ADDER)) i_adder (
      .a_i   (opa_i),
      .b_i   (opb_i),
      .cin_i (cin),
      .sum_o (sum),
      .cout_o(sum_c)
   );

   logic [WIDTH-1:0] shr;
   logic             shr_c;
   carry_alu_shifter #(.WIDTH(WIDTH)) i_shifter (
      .a_i      (opa_i),
      .cflag_i  (flags_q.c),
      .mode_i   (sub),
      .y_o      (shr),
      .out_bit_o(shr_c)
   );

   // Result selection
   logic [WIDTH-1:0] res;
   always_comb begin
      unique case (grp)
         GRP_LOGIC: begin
            unique case (sub)
               SUB_0:   res = sum;
               SUB_1:   res = opa_i;
               SUB_2:   res = ~(opa_i | opb_i);
               default: res = '0;
            endcase
         end
         GRP_ADD:   res = sum;
         GRP_SHIFT: res = shr;
         default:   res = opb_i;
      endcase
   end

   // Carry-out selection
   logic cout;
   always_comb begin
      unique case (grp)
         GRP_LOGIC: cout = (sub == SUB_0) ? flags_q.c : 1'b0;
         GRP_ADD:   cout = sum_c;
         GRP_SHIFT: cout = shr_c;
         default: begin
            unique case (sub)
               SUB_0:   cout = 1'b0;
               SUB_1:   cout = 1'b1;
               SUB_2:   cout = flags_q.c;
               default: cout = ~flags_q.c;
            endcase
         end
      endcase
   end

   assign res_o  = res;
   assign cout_o = cout;
   assign zero_o = ~|res;
   assign neg_o  = res[MSB];

   assign flags_d = '{c: cout, z: ~|res, n: res[MSB]};

   carry_alu_flags i_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (store),
      .next_i (flags_d),
      .flags_o(flags_q)
   );

   assign flag_c_o = flags_q.c;
   assign flag_z_o = flags_q.z;
   assign flag_n_o = flags_q.n;

   // R3: hold-carry add with a store leaves the stored carry alone
   p_hold_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fn == FN_ADD_HOLD && store) |=> flag_c_o == $past(flag_c_o));

   // R4: equal operands through the plain add shift left with a zero fill
   p_twin_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fn == FN_ADD && opa_i == opb_i) |->
         (res_o == {opa_i[MSB-1:0], 1'b0} && cout_o == opa_i[MSB]));

   // R5: logic, pass and clear codes never produce a carry
   p_logic_nocarry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fn == FN_PASS_A || fn == FN_NOR || fn == FN_CLEAR) |-> !cout_o);

   // R6: every right shift reports the bit leaving position 0
   p_shift_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (grp == GRP_SHIFT) |-> cout_o == opa_i[0]);

   // R8: set-carry pass with a store leaves the carry flag at 1
   p_setc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fn == FN_B_SETC && store) |=> flag_c_o);

   // R8: invert-carry pass with a store flips the carry flag
   p_invc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fn == FN_B_INVC && store) |=> flag_c_o != $past(flag_c_o));

endmodule

// File: tb/test_carry_alu.sv
module test_carry_alu;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [4:0] ctrl;
   logic [7:0] a, b;
   logic [7:0] res;
   logic       cout, zero, neg, fc, fz, fn;

   int checks = 0;
   int errors = 0;

   // Reference flags
   int mc = 0, mz = 0, mn = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   carry_alu i_carry_alu (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_i  (ctrl),
      .opa_i   (a),
      .opb_i   (b),
      .res_o   (res),
      .cout_o  (cout),
      .zero_o  (zero),
      .neg_o   (neg),
      .flag_c_o(fc),
      .flag_z_o(fz),
      .flag_n_o(fn)
   );

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // Drive one operation, check combinational outputs, then the flags after the edge.
   task automatic apply(input logic [4:0] c, input int x, input int y, input string tag);
      int r, co, s, cin;
      string rq;
      @(negedge clk);
      ctrl = c; a = x[7:0]; b = y[7:0];
      #1;
      case (c[4:1])
         4'b0000: begin s = x + y; r = s & 255; co = mc; rq = "R3"; end
         4'b0100, 4'b0101, 4'b0110, 4'b0111: begin
            case (c[2:1])
               2'b00:   cin = 0;
               2'b01:   cin = 1;
               2'b10:   cin = mc;
               default: cin = 1 - mc;
            endcase
            s = x + y + cin; r = s & 255; co = (s >> 8) & 1; rq = "R2";
         end
         4'b0001: begin r = x;               co = 0; rq = "R5"; end
         4'b0010: begin r = (~(x | y)) & 255; co = 0; rq = "R5"; end
         4'b0011: begin r = 0;               co = 0; rq = "R5"; end
         4'b1000: begin r = x >> 1;                   co = x & 1; rq = "R6"; end
         4'b1001: begin r = (x >> 1) | ((x & 1) << 7); co = x & 1; rq = "R6"; end
         4'b1010: begin r = (x >> 1) | (mc << 7);      co = x & 1; rq = "R7"; end
         4'b1011: begin r = (x >> 1) | (x & 128);      co = x & 1; rq = "R7"; end
         4'b1100: begin r = y; co = 0;      rq = "R8"; end
         4'b1101: begin r = y; co = 1;      rq = "R8"; end
         4'b1110: begin r = y; co = mc;     rq = "R8"; end
         default: begin r = y; co = 1 - mc; rq = "R8"; end
      endcase
      if (tag != "") rq = tag;
      check(rq, "result", int'(res), r);
      check(rq, "carry", int'(cout), co);
      check("R9", "zero", int'(zero), (r == 0) ? 1 : 0);
      check("R9", "neg", int'(neg), (r >> 7) & 1);
      @(posedge clk);
      if (c[0]) begin mc = co; mz = (r == 0) ? 1 : 0; mn = (r >> 7) & 1; end
      #1;
      check(c[0] ? "R10" : "R11", "flags", int'({fc, fz, fn}), (mc << 2) | (mz << 1) | mn);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; ctrl = '0; a = '0; b = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R10", "reset flags", int'({fc, fz, fn}), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R8: build a known carry, then invert and hold it
      apply(5'b11011, 8'h80, 8'h80, "");   // pass B set carry, store
      apply(5'b11111, 8'h00, 8'h00, "");   // invert carry -> 0, zero flag
      apply(5'b11111, 8'h00, 8'h7F, "");   // invert carry -> 1
      apply(5'b11101, 8'h00, 8'hFF, "");   // hold carry
      apply(5'b11001, 8'h00, 8'h01, "");   // pass B, carry 0
      // R3: hold-carry add keeps a set carry even on overflow-free sum
      apply(5'b11011, 8'h00, 8'h00, "");
      apply(5'b00001, 8'h10, 8'h20, "R3");
      apply(5'b00001, 8'hF0, 8'h20, "R3");
      // R2: each carry-in source
      apply(5'b01001, 8'hFF, 8'h01, "R2");
      apply(5'b01011, 8'h7F, 8'h00, "R2");
      apply(5'b01101, 8'h01, 8'h01, "R2");
      apply(5'b01111, 8'h01, 8'h01, "R2");
      // R1: only bits 4:1 select; store bit off, same code
      apply(5'b01100, 8'hFF, 8'hFF, "R1");
      apply(5'b11010, 8'h00, 8'h00, "R1");
      // R4: equal operands act as left shift
      apply(5'b01001, 8'h81, 8'h81, "R4");
      apply(5'b01011, 8'h40, 8'h40, "R4");
      apply(5'b11011, 8'h00, 8'h00, "");
      apply(5'b01101, 8'hC3, 8'hC3, "R4");
      apply(5'b01111, 8'h55, 8'h55, "R4");
      // R5
      apply(5'b00011, 8'hA5, 8'h3C, "R5");
      apply(5'b00101, 8'h0F, 8'hF0, "R5");
      apply(5'b00101, 8'h00, 8'h00, "R5");
      apply(5'b00111, 8'hFF, 8'hFF, "R5");
      // R6, R7 with both carry states
      apply(5'b10001, 8'h81, 8'h00, "R6");
      apply(5'b10011, 8'h81, 8'h00, "R6");
      apply(5'b10101, 8'h02, 8'h00, "R7");
      apply(5'b10101, 8'h03, 8'h00, "R7");
      apply(5'b10111, 8'h80, 8'h00, "R7");
      apply(5'b10111, 8'h41, 8'h00, "R7");
      // R11: no store leaves flags after a flag-changing operation
      apply(5'b11010, 8'h00, 8'h00, "R11");
      apply(5'b00110, 8'h00, 8'h00, "R11");

      for (int i = 0; i < 3000; i++) begin
         apply(5'($urandom), int'($urandom & 255), int'($urandom & 255), "");
      end
      for (int i = 0; i < 500; i++) begin
         int v;
         v = int'($urandom & 255);
         apply({2'b01, 2'($urandom), 1'b1}, v, v, "R4");
      end

      summary();
      $finish;
   end

endmodule